// File: doc/BRIEF.md
# Misaligned Access Splitter with Alignment Fault Check

The block stands between a load/store unit and a byte-addressed memory port. Each request carries an address, a size of 1, 2, 4, 8 or 16 bytes, an access class, an endian flag and three alignment controls. The block first decides whether the request takes an alignment fault. If it does, the fault is returned with no memory traffic. If it does not, the block issues one naturally aligned beat, or it splits the request into smaller beats that are each single-copy atomic.

Load data from the beats is merged into one right-justified value. Store data is sliced across the beats. When the endian flag is set, the whole value is byte-reversed. For loads this happens after merging, and for stores it happens before slicing. Only one memory beat is in flight at a time, and the request port stays busy until the response has been produced.

Top module: `mem_split_unit`

## Requirements
- R1: `req_size` encodes the byte count as 2^code (0=1, 1=2, 2=4, 3=8, 4=16). An access is aligned when its address, rounded down to a multiple of that count, is unchanged. An aligned access that does not fault is issued as exactly one beat, at the request address, with `mem_size` equal to `req_size`.
- R2: When `cfg_strict` is 1, every misaligned access faults, whatever its class.
- R3: When `cfg_strict` and `cfg_relaxed` are both 0, a misaligned access faults only if its class is atomic or ordered. The class codes are 0 plain, 1 atomic, 2 ordered, 3 ordered-atomic and 4 vector; codes 1 and 3 count as atomic, and codes 2 and 3 count as ordered.
- R4: When `cfg_strict` is 0 and `cfg_relaxed` is 1, a misaligned access faults only when both of these hold: address bits 3:0 plus the byte count exceed 16, and the access is atomic, or is ordered with `cfg_nonatomic_ok` at 0.
- R5: A misaligned access that does not fault is issued as one single-byte beat per byte, in ascending address order. Beat i uses address+i and carries data bits 8i+7:8i of the value.
- R6: A 16-byte vector access (class 4) whose address is a multiple of 8 but not of 16, and which does not fault, is issued as two 8-byte beats. The first beat carries the low half at the address, and the second carries the high half at address+8.
- R7: When `req_bigend` is 1, the value is byte-reversed across its byte count. For loads the reversal is applied to the merged load data, and for stores it is applied to the write data before slicing.
- R8: `req_ready` is low from the cycle after a request is accepted until its response has been given. At most one beat is presented at a time, and a beat holds its address and size until `mem_ready` accepts it.
- R9: A faulting request returns `rsp_valid` with `rsp_fault` at 1 in the cycle after it is accepted, and no memory beat is issued for it.
- R10: A non-faulting request returns `rsp_valid` for one cycle, in the cycle after its last beat is accepted. `rsp_rdata` holds the load value, with all bytes above the byte count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 3 | Byte count code (2^code) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 128 | Store value, right-justified |
| req_bigend | input | 1 | Byte-reverse the value |
| req_class | input | 3 | Access class code |
| cfg_strict | input | 1 | Fault on every misaligned access |
| cfg_relaxed | input | 1 | 16-byte-window relaxed alignment rule |
| cfg_nonatomic_ok | input | 1 | Ordered accesses may be non-atomic under the relaxed rule |
| mem_valid | output | 1 | Beat presented |
| mem_ready | input | 1 | Beat accepted and completed this cycle |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_size | output | 3 | Beat byte count code |
| mem_write | output | 1 | Beat is a store |
| mem_wdata | output | 128 | Beat store data, right-justified |
| mem_rdata | input | 128 | Beat load data, right-justified, valid with mem_ready |
| rsp_valid | output | 1 | Response for one cycle |
| rsp_fault | output | 1 | Request took an alignment fault |
| rsp_rdata | output | 128 | Merged load value |

## Verification
The bench builds the block with `ADDR_W` set to 12. It keeps every address below 240 inside a 256-byte memory model, so no split ever wraps and every beat address can be checked exactly. Beat acceptance is throttled at random, which exercises the holding of a beat over many cycles as well as back-to-back acceptance. All five byte counts, all five classes and every setting of the alignment controls are covered, including 16-byte vector accesses at 8-byte offsets and requests that cross the 16-byte window.

// File: rtl/msplit_pkg.sv
`timescale 1ns/1ps
package msplit_pkg;
    localparam int MAXB   = 16;
    localparam int DATA_W = MAXB * 8;
    localparam int SZ_W   = 3;
    localparam int CNT_W  = $clog2(MAXB) + 1;

    typedef enum logic [2:0] {
        ACC_PLAIN      = 3'd0,
        ACC_ATOMIC     = 3'd1,
        ACC_ORDERED    = 3'd2,
        ACC_ORD_ATOMIC = 3'd3,
        ACC_VECTOR     = 3'd4
    } acc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             fault;
        logic [SZ_W-1:0]  beat_sz;
        logic [CNT_W-1:0] nbeats;
    } split_plan_t;

    function automatic logic [DATA_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAXB; i++)
            if (i < (1 << sz)) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] byte_reverse(input logic [DATA_W-1:0] v,
                                                       input logic [SZ_W-1:0]   sz);
        logic [DATA_W-1:0] r;
        int n;
        n = 1 << sz;
        r = '0;
        for (int i = 0; i < MAXB; i++)
            if (i < n && (n - 1 - i) < MAXB) r[8*i +: 8] = v[8*(n-1-i) +: 8];
        return r;
    endfunction
endpackage

// File: rtl/msplit_align_chk.sv
`timescale 1ns/1ps
module msplit_align_chk
    import msplit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   sz,
    input  acc_class_e        cls,
    input  logic              strict,
    input  logic              relaxed,
    input  logic              nonatomic_ok,
    output split_plan_t       plan
);
    localparam int WIN_W = $clog2(MAXB);

    logic [WIN_W:0]   nbytes;
    logic [WIN_W-1:0] lo;
    logic [WIN_W-1:0] ofs_mask;
    logic             misalign, is_atomic, is_ordered, crosses, check, vec_pair;

    always_comb begin
        nbytes     = (WIN_W+1)'(1) << sz;
        lo         = addr[WIN_W-1:0];
        ofs_mask   = WIN_W'(nbytes - (WIN_W+1)'(1));
        misalign   = (lo & ofs_mask) != '0;
        is_atomic  = (cls == ACC_ATOMIC) || (cls == ACC_ORD_ATOMIC);
        is_ordered = (cls == ACC_ORDERED) || (cls == ACC_ORD_ATOMIC);
        crosses    = ({1'b0, lo} + nbytes) > (WIN_W+1)'(MAXB);
        if (strict)
            check = 1'b1;
        else if (relaxed)
            check = crosses && (is_atomic || (is_ordered && !nonatomic_ok));
        else
            check = is_atomic || is_ordered;
        vec_pair = (cls == ACC_VECTOR) && (sz == SZ_W'(4)) && (lo[2:0] == 3'b000);

        plan.fault   = check && misalign;
        plan.beat_sz = sz;
        plan.nbeats  = CNT_W'(1);
        if (plan.fault) begin
            plan.nbeats = '0;
        end else if (misalign && vec_pair) begin
            plan.beat_sz = SZ_W'(3);
            plan.nbeats  = CNT_W'(2);
        end else if (misalign) begin
            plan.beat_sz = '0;
            plan.nbeats  = CNT_W'(nbytes);
        end
    end
endmodule

// File: rtl/msplit_beat_seq.sv
`timescale 1ns/1ps
module msplit_beat_seq
    import msplit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  split_plan_t      plan_in,
    input  logic             beat_done,
    output seq_state_e       state,
    output split_plan_t      plan_q,
    output logic [CNT_W-1:0] beat_idx
);
    logic last_beat;
    assign last_beat = beat_idx == (plan_q.nbeats - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            plan_q   <= '0;
            beat_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    plan_q   <= plan_in;
                    beat_idx <= '0;
                    state    <= plan_in.fault ? ST_RESP : ST_BEAT;
                end
                ST_BEAT: if (beat_done) begin
                    if (last_beat) state <= ST_RESP;
                    else           beat_idx <= beat_idx + CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msplit_lane.sv
`timescale 1ns/1ps
module msplit_lane
    import msplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              bigend_in,
    input  logic [SZ_W-1:0]   sz_in,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [SZ_W-1:0]   beat_sz,
    input  logic              beat_done,
    input  logic [DATA_W-1:0] beat_rdata,
    output logic [DATA_W-1:0] beat_wdata,
    output logic [DATA_W-1:0] rsp_data
);
    logic [DATA_W-1:0] wval_q, acc_q, bmask;
    logic              bigend_q;
    logic [SZ_W-1:0]   sz_q;
    int                shamt;

    always_comb begin
        shamt      = (int'(beat_idx) << beat_sz) << 3;
        bmask      = size_mask(beat_sz);
        beat_wdata = (wval_q >> shamt) & bmask;
        rsp_data   = size_mask(sz_q) & (bigend_q ? byte_reverse(acc_q, sz_q) : acc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wval_q   <= '0;
            acc_q    <= '0;
            bigend_q <= 1'b0;
            sz_q     <= '0;
        end else if (capture) begin
            wval_q   <= bigend_in ? byte_reverse(wdata_in, sz_in) : wdata_in;
            acc_q    <= '0;
            bigend_q <= bigend_in;
            sz_q     <= sz_in;
        end else if (beat_done) begin
            acc_q <= (acc_q & ~(bmask << shamt)) | ((beat_rdata & bmask) << shamt);
        end
    end
endmodule

// File: rtl/mem_split_unit.sv
`timescale 1ns/1ps
module mem_split_unit
    import msplit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [127:0]      req_wdata,
    input  logic              req_bigend,
    input  logic [2:0]        req_class,
    input  logic              cfg_strict,
    input  logic              cfg_relaxed,
    input  logic              cfg_nonatomic_ok,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic              mem_write,
    output logic [127:0]      mem_wdata,
    input  logic [127:0]      mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [127:0]      rsp_rdata
);
    split_plan_t       plan_now, plan_q;
    seq_state_e        state;
    logic [CNT_W-1:0]  beat_idx;
    logic [ADDR_W-1:0] base_q;
    logic              write_q;
    logic              accept, beat_done, acc_fault;

    assign accept    = req_valid && req_ready;
    assign beat_done = mem_valid && mem_ready;
    assign acc_fault = plan_now.fault;

    msplit_align_chk #(.ADDR_W(ADDR_W)) u_align (
        .addr(req_addr), .sz(req_size), .cls(acc_class_e'(req_class)),
        .strict(cfg_strict), .relaxed(cfg_relaxed), .nonatomic_ok(cfg_nonatomic_ok),
        .plan(plan_now)
    );

    msplit_beat_seq u_seq (
        .clk(clk), .rst(rst), .start(accept), .plan_in(plan_now),
        .beat_done(beat_done), .state(state), .plan_q(plan_q), .beat_idx(beat_idx)
    );

    msplit_lane u_lane (
        .clk(clk), .rst(rst), .capture(accept), .wdata_in(req_wdata),
        .bigend_in(req_bigend), .sz_in(req_size), .beat_idx(beat_idx),
        .beat_sz(plan_q.beat_sz), .beat_done(beat_done), .beat_rdata(mem_rdata),
        .beat_wdata(mem_wdata), .rsp_data(rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            base_q  <= req_addr;
            write_q <= req_write;
        end
    end

    assign req_ready = state == ST_IDLE;
    assign mem_valid = state == ST_BEAT;
    assign rsp_valid = state == ST_RESP;
    assign rsp_fault = rsp_valid && plan_q.fault;
    assign mem_addr  = base_q + (ADDR_W'(beat_idx) << plan_q.beat_sz);
    assign mem_size  = plan_q.beat_sz;
    assign mem_write = write_q;
endmodule

// File: rtl/msplit_chk.sv
`timescale 1ns/1ps
module msplit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              acc_fault,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [2:0]        mem_size,
    input logic              rsp_valid,
    input logic              rsp_fault
);
    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_size));

    // R9
    fault_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && acc_fault |=> rsp_valid && rsp_fault && !mem_valid);

    // R1
    beat_natural_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr & ((ADDR_W'(1) << mem_size) - ADDR_W'(1))) == '0);

    // R10
    rsp_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> $past(mem_valid && mem_ready));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind mem_split_unit msplit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .acc_fault(acc_fault), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
);

// File: tb/mem_split_unit_test.sv
`timescale 1ns/1ps
module mem_split_unit_test;
    localparam int AW = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_bigend = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0] req_size = '0, req_class = '0;
    logic [127:0] req_wdata = '0;
    logic cfg_strict = 1'b0, cfg_relaxed = 1'b0, cfg_nonatomic_ok = 1'b0;
    logic mem_valid, mem_ready = 1'b0, mem_write;
    logic [AW-1:0] mem_addr;
    logic [2:0] mem_size;
    logic [127:0] mem_wdata, mem_rdata;
    logic rsp_valid, rsp_fault;
    logic [127:0] rsp_rdata;

    int tests = 0, fails = 0;
    logic [7:0] bmem [256];
    logic [7:0] rmem [256];
    int bcount = 0;
    logic [AW-1:0] log_addr [32];
    logic [2:0] log_sz [32];

    always #4 clk = ~clk;

    mem_split_unit #(.ADDR_W(AW)) uut (.*);

    always_comb
        for (int i = 0; i < 16; i++) mem_rdata[8*i +: 8] = bmem[8'(mem_addr[7:0] + 8'(i))];

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_write)
                for (int i = 0; i < (1 << mem_size); i++)
                    bmem[8'(mem_addr[7:0] + 8'(i))] <= mem_wdata[8*i +: 8];
            log_addr[bcount % 32] <= mem_addr;
            log_sz[bcount % 32]   <= mem_size;
            bcount <= bcount + 1;
        end
    end

    always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rev(input logic [127:0] v, input int n);
        logic [127:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
        return r;
    endfunction

    // expected fault and beat plan from the requirements
    task automatic model(input int addr, input int sz, input int cls, input logic st,
                         input logic rl, input logic nok,
                         output logic flt, output int nb, output int bsz);
        int n = 1 << sz;
        logic mis = (addr % n) != 0;
        logic at = (cls == 1) || (cls == 3);
        logic od = (cls == 2) || (cls == 3);
        logic ck;
        if (st) ck = 1;
        else if (rl) ck = ((addr % 16) + n > 16) && (at || (od && !nok));
        else ck = at || od;
        flt = ck && mis;
        if (flt) begin nb = 0; bsz = 0; end
        else if (!mis) begin nb = 1; bsz = sz; end
        else if (cls == 4 && sz == 4 && (addr % 8) == 0) begin nb = 2; bsz = 3; end
        else begin nb = n; bsz = 0; end
    endtask

    task automatic run(input int addr, input int sz, input logic wr, input logic [127:0] wd,
                       input logic be, input int cls, input logic st, input logic rl, input logic nok);
        logic flt; int nb, bsz, start, guard, n;
        logic busy_err = 0, beats_ok = 1;
        logic [127:0] exp = '0, got;
        logic got_f;
        string ftag, btag;
        n = 1 << sz;
        model(addr, sz, cls, st, rl, nok, flt, nb, bsz);
        @(negedge clk);
        req_valid = 1; req_addr = AW'(addr); req_size = 3'(sz); req_write = wr;
        req_wdata = wd; req_bigend = be; req_class = 3'(cls);
        cfg_strict = st; cfg_relaxed = rl; cfg_nonatomic_ok = nok;
        guard = 0;
        while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
        start = bcount;
        @(negedge clk);
        req_valid = 0;
        guard = 0;
        while (!rsp_valid && guard < 1000) begin
            if (req_ready) busy_err = 1;
            @(negedge clk); guard++;
        end
        got_f = rsp_fault; got = rsp_rdata;
        ftag = st ? "R2" : (rl ? "R4" : "R3");
        chk(rsp_valid && got_f == flt, ftag, 128'(got_f), 128'(flt));
        chk(!busy_err, "R8 busy", 128'(busy_err), 0);
        if (flt) begin
            chk(bcount == start, "R9 beats", 128'(bcount - start), 0);
            return;
        end
        btag = (nb == 1) ? "R1" : ((nb == 2) ? "R6" : "R5");
        if (bcount - start != nb) beats_ok = 0;
        else for (int k = 0; k < nb; k++)
            if (log_addr[(start + k) % 32] != AW'(addr + k * (1 << bsz)) ||
                int'(log_sz[(start + k) % 32]) != bsz) beats_ok = 0;
        chk(beats_ok, btag, 128'(bcount - start), 128'(nb));
        if (wr) begin
            logic [127:0] v = be ? rev(wd, n) : wd;
            logic ok = 1;
            for (int i = 0; i < n; i++) rmem[(addr + i) % 256] = v[8*i +: 8];
            for (int i = 0; i < 256; i++) if (bmem[i] != rmem[i]) ok = 0;
            chk(ok, be ? "R7 store" : {btag, " store"}, 128'(ok), 1);
        end else begin
            for (int i = 0; i < n; i++) exp[8*i +: 8] = rmem[(addr + i) % 256];
            if (be) exp = rev(exp, n);
            chk(got == exp, be ? "R7 load" : "R10 load", got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'($urandom);
            rmem[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !mem_valid && !rsp_valid, "R8 reset",
            128'({req_ready, mem_valid, rsp_valid}), 128'(3'b100));
        // directed corners
        run(8'h40, 3, 0, '0, 0, 0, 0, 0, 0);                 // R1 aligned load
        run(8'h41, 2, 0, '0, 0, 0, 0, 0, 0);                 // R5 byte split
        run(8'h42, 2, 1, 128'h1122_3344, 0, 1, 0, 0, 0);     // R3 atomic faults
        run(8'h21, 1, 1, 128'hBEEF, 0, 0, 1, 0, 0);          // R2 strict faults
        run(8'h0C, 3, 0, '0, 0, 2, 0, 1, 0);                 // R4 crosses, ordered
        run(8'h0C, 3, 1, 128'h0102_0304_0506_0708, 0, 2, 0, 1, 1); // R4 allowed
        run(8'h04, 3, 0, '0, 0, 1, 0, 1, 0);                 // R4 inside window
        run(8'h58, 4, 1, {4{32'hA5C3_0F1E}} ^ 128'h1, 0, 4, 0, 0, 0); // R6 halves
        run(8'h58, 4, 0, '0, 0, 4, 0, 0, 0);                 // R6 load halves
        run(8'h5C, 4, 0, '0, 0, 4, 0, 0, 0);                 // R5 vector bytes
        run(8'h80, 2, 1, 128'hDEAD_BEEF, 1, 0, 0, 0, 0);     // R7 store reversed
        run(8'h80, 2, 0, '0, 0, 0, 0, 0, 0);                 // R7 readback
        run(8'h83, 3, 0, '0, 1, 0, 0, 0, 0);                 // R7 split load reversed
        run(8'h10, 4, 0, '0, 0, 0, 0, 0, 0);                 // R10 full width
        for (int t = 0; t < 400; t++) begin
            int a = int'($urandom % 224);
            int s = int'($urandom % 5);
            int c = int'($urandom % 5);
            logic [127:0] w = {$urandom, $urandom, $urandom, $urandom};
            run(a, s, 1'($urandom), w, 1'($urandom), c, ($urandom % 4) == 0,
                1'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule